// File: doc/BRIEF.md
# Line Card Service-State Controller

This block keeps track of whether one hot-swappable line card is in service. It reads a front-panel push button, the card-present sense line, a hardware-fault line and two handshakes from the system: one that reports the card as ready and one that confirms its buffer memory has left the shared pool. From these inputs it drives a red fault LED, a green status LED, a request to attach the card's memory and a request to drain it.

A card that is present when reset ends, or that is plugged in later, starts bring-up with no operator action. While bring-up runs the green LED flashes. When the card reports ready, the green LED stays lit. To take a working card out of service, the operator holds the button for a set number of seconds. The block then asks for the card's memory to be drained and holds the green LED lit. When the drain is confirmed, the green LED goes dark and the card can be pulled. The same long hold on a card that is out of service starts bring-up again. A hardware fault overrides every other state and lights the red LED. The fault state is left only through an explicit clear.

Top module: `card_svc_ctrl`

## Requirements
- R1: A button press held for less than HOLD_SEC*CYCLES_PER_SEC cycles, after debouncing, changes no output in any state.
- R2: A long hold on an in-service card drops mem_attach and raises mem_drain while the green LED stays lit. A drain_done pulse then ends the drain: green, mem_drain and mem_attach all go low.
- R3: A long hold on an out-of-service card that is present starts bring-up. mem_attach goes high and the green LED toggles every CYCLES_PER_SEC/(2*BLINK_HZ) cycles. With no card present the hold has no effect.
- R4: A card_ready pulse during bring-up puts the card in service: green lit steadily, mem_attach high. card_ready has no effect outside bring-up.
- R5: hw_fault high forces the fault state from any state on the next clock. In that state red is lit, green is dark, both memory requests are low, and the button has no effect.
- R6: fault_clear leaves the fault state for out-of-service (all outputs low) only while hw_fault is low. While hw_fault is high, fault_clear is ignored.
- R7: A card present when reset ends, or a rising edge on card_present while out of service, starts bring-up without a button press. Dropping card_present during bring-up, in service or during drain returns the card to out of service.
- R8: While rst_n is low, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_raw | input | 1 | Asynchronous, bouncing push-button level, high when pressed |
| card_present | input | 1 | High while a card is seated |
| card_ready | input | 1 | Card reports that bring-up is complete |
| drain_done | input | 1 | Card memory has been withdrawn from the shared pool |
| hw_fault | input | 1 | Hardware fault on the card (level) |
| fault_clear | input | 1 | Request to leave the fault state |
| led_green | output | 1 | Status LED: flashing during bring-up, lit in service and during drain |
| led_red | output | 1 | Fault LED |
| mem_attach | output | 1 | Request to keep the card's memory in the shared pool |
| mem_drain | output | 1 | Request to withdraw the card's memory from the pool |

## Verification
Each internal state has its own combination of LED pattern and memory requests. A wrong state therefore shows at the ports on the clock edge right after the faulty transition. The exception is a confusion between bring-up and in service, which shows only as a missing or an extra green toggle within one blink half-period. A hold timer that is wrong shows as a state change during a short press, or as no change after a long one. Both become visible within a few debounce windows after the release. A fault that does not latch shows as the red LED dropping once the fault pulse ends.

// File: rtl/card_svc_pkg.sv
package card_svc_pkg;

  typedef enum logic [2:0] {
    CS_OFFLINE = 3'd0,
    CS_BRINGUP = 3'd1,
    CS_ONLINE  = 3'd2,
    CS_DRAIN   = 3'd3,
    CS_FAILED  = 3'd4
  } card_st_e;

  // Total long-press length in clock cycles.
  function automatic int unsigned hold_cycles(input int unsigned cps,
                                              input int unsigned sec);
    int unsigned n;
    n = cps * sec;
    return (n < 2) ? 2 : n;
  endfunction

  // Cycles per half period of the bring-up flash.
  function automatic int unsigned blink_half(input int unsigned cps,
                                             input int unsigned hz);
    int unsigned n;
    n = cps / (2 * ((hz == 0) ? 1 : hz));
    return (n < 1) ? 1 : n;
  endfunction

  // Width of a counter that must reach the value n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Service-state transition; a fault outranks every other input.
  function automatic card_st_e next_state(input card_st_e cur,
                                          input logic fault,
                                          input logic clr,
                                          input logic present,
                                          input logic inserted,
                                          input logic lp,
                                          input logic ready,
                                          input logic done);
    card_st_e nxt;
    nxt = cur;
    if (fault) begin
      nxt = CS_FAILED;
    end else begin
      case (cur)
        CS_OFFLINE: if (present && (inserted || lp)) nxt = CS_BRINGUP;
        CS_BRINGUP: if (!present) nxt = CS_OFFLINE;
                    else if (ready) nxt = CS_ONLINE;
        CS_ONLINE:  if (!present) nxt = CS_OFFLINE;
                    else if (lp) nxt = CS_DRAIN;
        CS_DRAIN:   if (!present || done) nxt = CS_OFFLINE;
        CS_FAILED:  if (clr) nxt = CS_OFFLINE;
        default:    nxt = CS_OFFLINE;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned DEB_CYC = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int unsigned W = card_svc_pkg::cnt_bits(DEB_CYC);
  localparam logic [W-1:0] LAST = W'((DEB_CYC < 1) ? 0 : DEB_CYC - 1);

  logic sync_a, sync_b;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      level  <= 1'b0;
      cnt    <= '0;
    end else begin
      sync_a <= raw;
      sync_b <= sync_a;
      if (sync_b == level) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        level <= sync_b;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned HOLD_CYC = 150_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pressed,
  output logic long_press
);
  localparam int unsigned W = card_svc_pkg::cnt_bits(HOLD_CYC);
  localparam logic [W-1:0] FULL = W'(HOLD_CYC);
  localparam logic [W-1:0] FIRE = W'(HOLD_CYC - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !pressed) cnt <= '0;
    else if (cnt != FULL)   cnt <= cnt + 1'b1;
  end

  // One pulse per hold, on the cycle the count reaches its limit.
  assign long_press = pressed && (cnt == FIRE);
endmodule

// File: rtl/blink_gen.sv
module blink_gen #(
  parameter int unsigned HALF_CYC = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic phase
);
  localparam int unsigned W = card_svc_pkg::cnt_bits(HALF_CYC);
  localparam logic [W-1:0] LAST = W'(HALF_CYC - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/card_svc_ctrl.sv
module card_svc_ctrl
  import card_svc_pkg::*;
#(
  parameter int unsigned CYCLES_PER_SEC = 50_000_000,
  parameter int unsigned HOLD_SEC       = 3,
  parameter int unsigned DEBOUNCE_CYC   = 500_000,
  parameter int unsigned BLINK_HZ       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  input  logic card_present,
  input  logic card_ready,
  input  logic drain_done,
  input  logic hw_fault,
  input  logic fault_clear,
  output logic led_green,
  output logic led_red,
  output logic mem_attach,
  output logic mem_drain
);
  localparam int unsigned HOLD_CYC = hold_cycles(CYCLES_PER_SEC, HOLD_SEC);
  localparam int unsigned HALF_CYC = blink_half(CYCLES_PER_SEC, BLINK_HZ);

  // Named internal events, also observed by the checker.
  logic     btn_level;
  logic     long_press;
  logic     blink_ph;
  logic     present_q;
  logic     inserted;
  card_st_e state;
  card_st_e state_nxt;

  btn_debounce #(.DEB_CYC(DEBOUNCE_CYC)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (btn_raw),
    .level (btn_level)
  );

  hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .pressed    (btn_level),
    .long_press (long_press)
  );

  blink_gen #(.HALF_CYC(HALF_CYC)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state == CS_BRINGUP),
    .phase (blink_ph)
  );

  // present_q resets low so a card seated at reset reads as an insertion.
  assign inserted = card_present && !present_q;

  always_comb begin
    state_nxt = next_state(state, hw_fault, fault_clear, card_present,
                           inserted, long_press, card_ready, drain_done);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= CS_OFFLINE;
      present_q <= 1'b0;
    end else begin
      state     <= state_nxt;
      present_q <= card_present;
    end
  end

  always_comb begin
    led_green  = 1'b0;
    led_red    = 1'b0;
    mem_attach = 1'b0;
    mem_drain  = 1'b0;
    case (state)
      CS_BRINGUP: begin led_green = blink_ph; mem_attach = 1'b1; end
      CS_ONLINE:  begin led_green = 1'b1;     mem_attach = 1'b1; end
      CS_DRAIN:   begin led_green = 1'b1;     mem_drain  = 1'b1; end
      CS_FAILED:  led_red = 1'b1;
      default:    ;
    endcase
  end
endmodule

// File: rtl/card_svc_chk.sv
module card_svc_chk
  import card_svc_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     hw_fault,
  input logic     card_present,
  input logic     card_ready,
  input logic     drain_done,
  input logic     btn_level,
  input logic     long_press,
  input logic     led_green,
  input logic     led_red,
  input logic     mem_attach,
  input logic     mem_drain,
  input card_st_e state
);
  AST_LONG_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    long_press |-> (btn_level && $past(btn_level))); // R1

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_attach && mem_drain)); // R2

  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_drain && drain_done && !hw_fault) |=> (!mem_drain && !led_green && !mem_attach)); // R2

  AST_READY_ONLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_BRINGUP && card_ready && card_present && !hw_fault)
      |=> (led_green && mem_attach && !mem_drain)); // R4

  AST_FAULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fault |=> (led_red && !led_green)); // R5

  AST_RED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    led_red |-> (!mem_attach && !mem_drain && !led_green)); // R5

  AST_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fault && led_red) |=> led_red); // R6
endmodule

bind card_svc_ctrl card_svc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hw_fault     (hw_fault),
  .card_present (card_present),
  .card_ready   (card_ready),
  .drain_done   (drain_done),
  .btn_level    (btn_level),
  .long_press   (long_press),
  .led_green    (led_green),
  .led_red      (led_red),
  .mem_attach   (mem_attach),
  .mem_drain    (mem_drain),
  .state        (state)
);

// File: tb/card_svc_ctrl_tb.sv
module card_svc_ctrl_tb;
  localparam int unsigned CPS   = 20;
  localparam int unsigned HSEC  = 3;
  localparam int unsigned DEB   = 4;
  localparam int unsigned BHZ   = 2;
  localparam int unsigned HOLD  = CPS * HSEC;        // 60 cycles
  localparam int unsigned HALF  = CPS / (2 * BHZ);   // 5 cycles

  // Operations
  localparam logic [3:0] OP_IDLE = 4'd0, OP_SHORT = 4'd1, OP_LONG = 4'd2,
    OP_READY = 4'd3, OP_DONE = 4'd4, OP_FAULT = 4'd5, OP_CLEAR = 4'd6,
    OP_REMOVE = 4'd7, OP_INSERT = 4'd8, OP_FLTCLR = 4'd9;
  // Green expectation
  localparam logic [1:0] G_OFF = 2'd0, G_ON = 2'd1, G_BLINK = 2'd2;

  // {op, green, red, attach, drain, requirement number}
  localparam int NV = 24;
  localparam logic [12:0] VEC [NV] = '{
    {OP_IDLE,   G_BLINK, 1'b0, 1'b1, 1'b0, 4'd7},
    {OP_READY,  G_ON,    1'b0, 1'b1, 1'b0, 4'd4},
    {OP_SHORT,  G_ON,    1'b0, 1'b1, 1'b0, 4'd1},
    {OP_LONG,   G_ON,    1'b0, 1'b0, 1'b1, 4'd2},
    {OP_DONE,   G_OFF,   1'b0, 1'b0, 1'b0, 4'd2},
    {OP_SHORT,  G_OFF,   1'b0, 1'b0, 1'b0, 4'd1},
    {OP_LONG,   G_BLINK, 1'b0, 1'b1, 1'b0, 4'd3},
    {OP_SHORT,  G_BLINK, 1'b0, 1'b1, 1'b0, 4'd1},
    {OP_READY,  G_ON,    1'b0, 1'b1, 1'b0, 4'd4},
    {OP_FAULT,  G_OFF,   1'b1, 1'b0, 1'b0, 4'd5},
    {OP_LONG,   G_OFF,   1'b1, 1'b0, 1'b0, 4'd5},
    {OP_FLTCLR, G_OFF,   1'b1, 1'b0, 1'b0, 4'd6},
    {OP_CLEAR,  G_OFF,   1'b0, 1'b0, 1'b0, 4'd6},
    {OP_REMOVE, G_OFF,   1'b0, 1'b0, 1'b0, 4'd7},
    {OP_LONG,   G_OFF,   1'b0, 1'b0, 1'b0, 4'd3},
    {OP_INSERT, G_BLINK, 1'b0, 1'b1, 1'b0, 4'd7},
    {OP_REMOVE, G_OFF,   1'b0, 1'b0, 1'b0, 4'd7},
    {OP_INSERT, G_BLINK, 1'b0, 1'b1, 1'b0, 4'd7},
    {OP_READY,  G_ON,    1'b0, 1'b1, 1'b0, 4'd4},
    {OP_LONG,   G_ON,    1'b0, 1'b0, 1'b1, 4'd2},
    {OP_FAULT,  G_OFF,   1'b1, 1'b0, 1'b0, 4'd5},
    {OP_CLEAR,  G_OFF,   1'b0, 1'b0, 1'b0, 4'd6},
    {OP_READY,  G_OFF,   1'b0, 1'b0, 1'b0, 4'd4},
    {OP_LONG,   G_BLINK, 1'b0, 1'b1, 1'b0, 4'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_raw = 1'b0, card_present = 1'b1, card_ready = 1'b0;
  logic drain_done = 1'b0, hw_fault = 1'b0, fault_clear = 1'b0;
  logic led_green, led_red, mem_attach, mem_drain;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  card_svc_ctrl #(
    .CYCLES_PER_SEC(CPS), .HOLD_SEC(HSEC), .DEBOUNCE_CYC(DEB), .BLINK_HZ(BHZ)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .card_present(card_present),
    .card_ready(card_ready), .drain_done(drain_done), .hw_fault(hw_fault),
    .fault_clear(fault_clear), .led_green(led_green), .led_red(led_red),
    .mem_attach(mem_attach), .mem_drain(mem_drain)
  );

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int n);
    btn_raw = 1'b1;
    wait_cyc(n);
    btn_raw = 1'b0;
  endtask

  task automatic do_op(input logic [3:0] op);
    case (op)
      OP_SHORT:  press(HOLD / 2);
      OP_LONG:   press(HOLD + 12);
      OP_READY:  begin card_ready = 1'b1; wait_cyc(2); card_ready = 1'b0; end
      OP_DONE:   begin drain_done = 1'b1; wait_cyc(2); drain_done = 1'b0; end
      OP_FAULT:  begin hw_fault = 1'b1; wait_cyc(3); hw_fault = 1'b0; end
      OP_CLEAR:  begin fault_clear = 1'b1; wait_cyc(2); fault_clear = 1'b0; end
      OP_REMOVE: card_present = 1'b0;
      OP_INSERT: card_present = 1'b1;
      OP_FLTCLR: begin
        hw_fault = 1'b1; fault_clear = 1'b1; wait_cyc(2);
        fault_clear = 1'b0; wait_cyc(2); hw_fault = 1'b0;
      end
      default:   wait_cyc(1);
    endcase
  endtask

  // Observe the outputs for a window and compare with one expectation.
  task automatic observe(input int idx, input logic [1:0] g, input logic r,
                         input logic a, input logic d, input string tag);
    int toggles = 0;
    bit other_bad = 1'b0;
    logic g_first, g_prev;
    g_first = led_green;
    g_prev  = led_green;
    for (int k = 0; k < 8 * HALF; k++) begin
      if (led_green != g_prev) toggles++;
      g_prev = led_green;
      if (led_red !== r || mem_attach !== a || mem_drain !== d) other_bad = 1'b1;
      wait_cyc(1);
    end
    n_checks++;
    if (other_bad ||
        (g == G_BLINK && toggles < 3) ||
        (g != G_BLINK && (toggles != 0 || g_first !== g[0]))) begin
      n_errors++;
      $display("FAIL %s step %0d: green=%b toggles=%0d red=%b att=%b drn=%b, expected green_mode=%0d red=%b att=%b drn=%b",
               tag, idx, g_first, toggles, led_red, mem_attach, mem_drain, g, r, a, d);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    report();
  end

  initial begin
    // R8: outputs stay low throughout reset, even with a card seated.
    wait_cyc(5);
    n_checks++;
    if ({led_green, led_red, mem_attach, mem_drain} !== 4'b0000) begin
      n_errors++;
      $display("FAIL R8 reset: outputs=%b expected=0000",
               {led_green, led_red, mem_attach, mem_drain});
    end
    // R8: a fault asserted during reset still leaves the outputs low.
    hw_fault = 1'b1;
    wait_cyc(3);
    n_checks++;
    if ({led_green, led_red, mem_attach, mem_drain} !== 4'b0000) begin
      n_errors++;
      $display("FAIL R8 reset with fault: outputs=%b expected=0000",
               {led_green, led_red, mem_attach, mem_drain});
    end
    hw_fault = 1'b0;
    rst_n = 1'b1;
    wait_cyc(2);

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      do_op(v[12:9]);
      wait_cyc(3 * DEB + 4);
      observe(i, v[8:7], v[6], v[5], v[4], req_name(v[3:0]));
    end

    // R1: a bouncing press that never settles must not act, even if held long.
    for (int k = 0; k < HOLD; k++) begin
      btn_raw = ~btn_raw;
      wait_cyc(2);
    end
    btn_raw = 1'b0;
    wait_cyc(3 * DEB + 4);
    observe(100, G_BLINK, 1'b0, 1'b1, 1'b0, "R1");

    // R3: exact flash half period during bring-up.
    begin
      int t_first = -1;
      int t_second = -1;
      logic prev;
      prev = led_green;
      for (int k = 0; k < 4 * HALF; k++) begin
        wait_cyc(1);
        if (led_green != prev) begin
          if (t_first < 0) t_first = k;
          else if (t_second < 0) t_second = k;
        end
        prev = led_green;
      end
      n_checks++;
      if (t_first < 0 || t_second - t_first != int'(HALF)) begin
        n_errors++;
        $display("FAIL R3 blink period: spacing=%0d expected=%0d",
                 t_second - t_first, HALF);
      end
    end

    // R5: a fault takes effect on the next clock.
    @(negedge clk);
    hw_fault = 1'b1;
    @(negedge clk);
    n_checks++;
    if (led_red !== 1'b1 || led_green !== 1'b0 || mem_attach !== 1'b0) begin
      n_errors++;
      $display("FAIL R5 fault latency: red=%b green=%b att=%b expected red=1 green=0 att=0",
               led_red, led_green, mem_attach);
    end
    hw_fault = 1'b0;
    wait_cyc(4);

    report();
  end
endmodule